// File: doc/BRIEF.md
# UART receive FIFO with break detection

This block is the receive half of a serial port. It watches a serial data line through a sampling strobe that runs at sixteen times the bit rate. It checks each start bit and samples every following bit near its centre. It then assembles 8-bit characters, with an optional parity bit, and stores the clean ones in a 16-entry first-in first-out buffer. A host takes bytes out through a simple read strobe. It can see the current fill level in a 16-bit count word.

Sticky status flags report four conditions: the buffer has reached a programmable fill threshold, a character had a bad stop bit, a character had a parity mismatch, or a byte was lost because the buffer was full. A separate break flag reports a line held low. While the line stays in break, the receiver keeps running but stores nothing, and the break flag keeps coming back after software clears it. The raw line level is brought out, so software can tell a real break from an ordinary framing error.

Top module: `uart_rx_fifo`

## Requirements
- R1: With `os_tick` high, a low line seen on a tick opens a start bit. The start is accepted only if the line is still low on the 8th tick after that. Data bits are then sampled every 16 ticks, least significant bit first, followed by an optional parity bit and one stop bit.
- R2: If the line is high at the 8th-tick check, the receiver drops the start, hunts for a new one, and stores and flags nothing.
- R3: A character with a high stop bit and correct parity is written to a 16-entry buffer. `rd_data` shows the oldest entry. `rd_en` removes it when the buffer is not empty, and is ignored when it is empty. Bytes leave in arrival order.
- R4: `fill_reg[7:0]` holds the number of stored bytes and `fill_reg[15:8]` reads zero.
- R5: `trig_sel` codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 bytes. `rdf` sets whenever the fill count is at or above the selected threshold.
- R6: `rdf` stays set until `clr_full` is pulsed. If the count is still at or above the threshold during the clear, `rdf` is set again. If the count is below it, `rdf` stays clear.
- R7: With `par_en` high, a parity bit follows the data: `par_odd`=1 selects odd parity and 0 selects even parity. A mismatch sets `perr` and the byte is not stored.
- R8: A low stop bit sets `ferr` and the byte is not stored.
- R9: A character whose data bits are all zero and whose stop bit is low starts a break and sets `brk`. During a break no byte is stored. The break ends once the line has been high for 16 consecutive ticks, and reception then resumes with a fresh start-bit hunt.
- R10: While in break with the line low, `brk` is set again in the cycle after any `clr_brk` pulse.
- R11: `rxd_level` follows `rxd` directly.
- R12: A clean byte that arrives while the buffer is full, with no read in the same cycle, is dropped. The stored bytes stay unchanged and `ovr` is set until `clr_ovr` is pulsed.
- R13: A store and a read in the same cycle both take effect and leave the count unchanged. When the buffer is full, this lets the new byte in without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial data line, synchronous to clk |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| trig_sel | input | 2 | Fill threshold select |
| rd_en | input | 1 | Remove the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| fill_reg | output | 16 | Fill count in the low byte |
| rxd_level | output | 1 | Raw line level |
| clr_full | input | 1 | Clear `rdf` |
| clr_ferr | input | 1 | Clear `ferr` |
| clr_perr | input | 1 | Clear `perr` |
| clr_brk | input | 1 | Clear `brk` |
| clr_ovr | input | 1 | Clear `ovr` |
| rdf | output | 1 | Fill threshold reached |
| ferr | output | 1 | Framing error |
| perr | output | 1 | Parity error |
| brk | output | 1 | Break detected |
| ovr | output | 1 | Overrun |

## Verification
The store of a finished character and a host read can land on the same clock edge. The bench provokes this by raising `rd_en` for the single cycle in which the stop bit is sampled, since it counts bit times from the start edge. It does this once with one byte stored and once with the buffer full. It judges the result by the count staying put, `ovr` staying clear, and the new byte coming out last when the buffer is drained. A second collision, a flag clear meeting a flag set, is checked by pulsing `clr_full` and `clr_brk` while their set conditions still hold.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // fill threshold picked by the 2-bit select
  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // parity bit that a correct sender puts on the line
  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              restart,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              stop_ok,
  output logic              par_ok
);
  localparam int CNT_W = $clog2(OS);
  localparam int BW    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OS - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              pbit, pen_q, podd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_HUNT;
      cnt    <= '0;
      bidx   <= '0;
      shreg  <= '0;
      pbit   <= 1'b0;
      pen_q  <= 1'b0;
      podd_q <= 1'b0;
    end else if (restart) begin
      state <= ST_HUNT;
      cnt   <= '0;
    end else if (tick) begin
      case (state)
        ST_HUNT: if (!rxd) begin
          state  <= ST_START;
          cnt    <= '0;
          pen_q  <= par_en;
          podd_q <= par_odd;
        end
        ST_START: if (cnt == MID) begin
          cnt  <= '0;
          bidx <= '0;
          state <= rxd ? ST_HUNT : ST_DATA;
        end else cnt <= cnt + 1'b1;
        ST_DATA: if (cnt == LAST) begin
          cnt   <= '0;
          shreg <= {rxd, shreg[DATA_W-1:1]};
          if (bidx == BW'(DATA_W - 1)) state <= pen_q ? ST_PAR : ST_STOP;
          else bidx <= bidx + 1'b1;
        end else cnt <= cnt + 1'b1;
        ST_PAR: if (cnt == LAST) begin
          cnt   <= '0;
          pbit  <= rxd;
          state <= ST_STOP;
        end else cnt <= cnt + 1'b1;
        ST_STOP: if (cnt == LAST) begin
          cnt   <= '0;
          state <= ST_HUNT;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign frame_done = tick && !restart && (state == ST_STOP) && (cnt == LAST);
  assign frame_data = shreg;
  assign stop_ok    = rxd;
  assign par_ok     = !pen_q || (pbit == par_bit(shreg, podd_q));

endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr) wptr <= nxt(wptr);
      if (rd) rptr <= nxt(rptr);
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        trig_sel,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [15:0]       fill_reg,
  output logic              rxd_level,
  input  logic              clr_full,
  input  logic              clr_ferr,
  input  logic              clr_perr,
  input  logic              clr_brk,
  input  logic              clr_ovr,
  output logic              rdf,
  output logic              ferr,
  output logic              perr,
  output logic              brk,
  output logic              ovr
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int HCW   = $clog2(OS);
  localparam logic [HCW-1:0] HI_LAST = HCW'(OS - 1);

  // named internal events, observed by the bound checker
  logic              frame_done, stop_ok, par_ok;
  logic [DATA_W-1:0] frame_data;
  logic              good, push_ok, pop_ok, drop, lvl_hit;
  logic              brk_active, brk_start, brk_end;
  logic [HCW-1:0]    hi_cnt;
  logic [CW-1:0]     fifo_cnt;
  logic              full, empty;

  uart_rx_deser #(.DATA_W(DATA_W), .OS(OS)) deser_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (os_tick),
    .rxd        (rxd),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .restart    (brk_end),
    .frame_done (frame_done),
    .frame_data (frame_data),
    .stop_ok    (stop_ok),
    .par_ok     (par_ok)
  );

  assign pop_ok    = rd_en && !empty;
  assign good      = frame_done && stop_ok && par_ok && !brk_active;
  assign push_ok   = good && (!full || pop_ok);
  assign drop      = good && full && !pop_ok;
  assign brk_start = frame_done && !stop_ok && (frame_data == '0);
  assign brk_end   = brk_active && os_tick && rxd && (hi_cnt == HI_LAST);
  assign lvl_hit   = 32'(fifo_cnt) >= trig_level(trig_sel);

  rx_byte_fifo #(.DEPTH(DEPTH), .W(DATA_W)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (push_ok),
    .wdata (frame_data),
    .rd    (pop_ok),
    .rdata (rd_data),
    .count (fifo_cnt),
    .full  (full),
    .empty (empty)
  );

  // break state and the high-time counter that ends it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_active <= 1'b0;
      hi_cnt     <= '0;
    end else begin
      if (brk_start)    brk_active <= 1'b1;
      else if (brk_end) brk_active <= 1'b0;
      if (!brk_active || !rxd) hi_cnt <= '0;
      else if (os_tick)        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // sticky flags: a set in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdf  <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
      brk  <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      rdf  <= (rdf  & ~clr_full) | lvl_hit;
      ferr <= (ferr & ~clr_ferr) | (frame_done & ~stop_ok);
      perr <= (perr & ~clr_perr) | (frame_done & ~par_ok);
      brk  <= (brk  & ~clr_brk)  | brk_start | (brk_active & ~rxd);
      ovr  <= (ovr  & ~clr_ovr)  | drop;
    end
  end

  assign fill_reg  = {8'h00, 8'(fifo_cnt)};
  assign rxd_level = rxd;

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rxd,
  input logic                       frame_done,
  input logic                       stop_ok,
  input logic                       good,
  input logic                       full,
  input logic                       push_ok,
  input logic                       pop_ok,
  input logic                       brk_active,
  input logic                       lvl_hit,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic                       rdf,
  input logic                       ferr,
  input logic                       brk,
  input logic                       ovr
);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fifo_cnt) <= DEPTH);

  a_r6_rdf_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_hit |=> rdf);

  a_r8_ferr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !stop_ok) |=> ferr);

  a_r9_brk_withhold: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && frame_done) |-> !push_ok);

  a_r10_brk_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && !rxd) |=> brk);

  a_r12_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (good && full && !pop_ok) |=> (ovr && fifo_cnt == $past(fifo_cnt)));

  a_r13_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> (fifo_cnt == $past(fifo_cnt)));

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rxd        (rxd),
  .frame_done (frame_done),
  .stop_ok    (stop_ok),
  .good       (good),
  .full       (full),
  .push_ok    (push_ok),
  .pop_ok     (pop_ok),
  .brk_active (brk_active),
  .lvl_hit    (lvl_hit),
  .fifo_cnt   (fifo_cnt),
  .rdf        (rdf),
  .ferr       (ferr),
  .brk        (brk),
  .ovr        (ovr)
);

// File: tb/uart_rx_fifo_tb_top.sv
module uart_rx_fifo_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b1;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0, par_odd = 1'b0;
  logic [1:0] trig_sel = 2'd3;
  logic       rd_en = 1'b0;
  logic       clr_full = 1'b0, clr_ferr = 1'b0, clr_perr = 1'b0;
  logic       clr_brk = 1'b0, clr_ovr = 1'b0;
  logic [7:0] rd_data;
  logic [15:0] fill_reg;
  logic       rxd_level, rdf, ferr, perr, brk, ovr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .trig_sel(trig_sel),
    .rd_en(rd_en), .rd_data(rd_data), .fill_reg(fill_reg),
    .rxd_level(rxd_level), .clr_full(clr_full), .clr_ferr(clr_ferr),
    .clr_perr(clr_perr), .clr_brk(clr_brk), .clr_ovr(clr_ovr),
    .rdf(rdf), .ferr(ferr), .perr(perr), .brk(brk), .ovr(ovr)
  );

  // fields: data[14:7] pe[6] odd[5] flip[4] stop[3] push[2] perr[1] ferr[0]
  localparam logic [14:0] VECS [7] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h81, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // one character, 16 clocks per bit; optional read in the stop-sample cycle
  task automatic send(input logic [7:0] d, input bit pe, input bit podd,
                      input bit flip, input bit stop, input bit pop_at_push);
    par_en  = pe;
    par_odd = podd;
    hold(1'b0, 16);
    for (int b = 0; b < 8; b++) hold(d[b], 16);
    if (pe) hold((podd ? ~^d : ^d) ^ flip, 16);
    rxd = stop;
    for (int i = 0; i < 16; i++) begin
      if (i == 8) rd_en = pop_at_push;
      if (i == 9) rd_en = 1'b0;
      @(negedge clk);
    end
    hold(1'b1, 20);
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    {clr_full, clr_ferr, clr_perr, clr_brk, clr_ovr} = 5'b11111;
    @(negedge clk);
    {clr_full, clr_ferr, clr_perr, clr_brk, clr_ovr} = 5'b00000;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_q [$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R4 count after reset", fill_reg, 16'h0000);
    chk("R6 rdf after reset", rdf, 0);
    chk("R11 line level high", rxd_level, 1);

    // short low glitch: start rejected at the 8th tick
    rxd = 1'b0;
    @(negedge clk);
    chk("R11 line level low", rxd_level, 0);
    hold(1'b0, 3);
    hold(1'b1, 40);
    chk("R2 false start stores nothing", fill_reg, 16'h0000);
    chk("R2 false start flags nothing", {ferr, perr, brk}, 0);

    // vector table
    for (int v = 0; v < 7; v++) begin
      logic [14:0] e;
      e = VECS[v];
      send(e[14:7], e[6], e[5], e[4], e[3], 1'b0);
      chk("R1 R3 R7 R8 stored count", fill_reg, {15'd0, e[2]});
      chk("R7 parity error flag", perr, e[1]);
      chk("R8 framing error flag", ferr, e[0]);
      if (e[2]) begin
        chk("R1 received byte value", rd_data, e[14:7]);
        pop();
      end
      clear_all();
    end

    // thresholds and re-arm
    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) send(8'h10 + 8'(i), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 below level 4", rdf, 0);
    send(8'h13, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R5 at level 4", rdf, 1);
    chk("R4 count four", fill_reg, 16'h0004);
    clr_full = 1'b1; @(negedge clk); clr_full = 1'b0;
    chk("R6 clear at level re-arms", rdf, 1);
    pop();
    chk("R6 sticky below level", rdf, 1);
    clr_full = 1'b1; @(negedge clk); clr_full = 1'b0;
    chk("R6 clear below level holds", rdf, 0);
    trig_sel = 2'd0; @(negedge clk);
    chk("R5 level 1 reached", rdf, 1);
    trig_sel = 2'd3;
    clr_full = 1'b1; @(negedge clk); clr_full = 1'b0;
    chk("R5 level 14 not reached", rdf, 0);
    for (int i = 1; i < 4; i++) begin
      chk("R3 read order", rd_data, 8'h10 + 8'(i));
      pop();
    end
    pop();
    chk("R3 read on empty ignored", fill_reg, 16'h0000);

    // fill, overrun, then a store and a read together at full
    trig_sel = 2'd2;
    for (int i = 0; i < 16; i++) send(8'h40 + 8'(i), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 count sixteen", fill_reg, 16'h0010);
    chk("R5 level 8 reached", rdf, 1);
    send(8'hEE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R12 count stays full", fill_reg, 16'h0010);
    chk("R12 overrun flag", ovr, 1);
    chk("R12 head unchanged", rd_data, 8'h40);
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
    chk("R12 overrun cleared", ovr, 0);
    send(8'hC7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R13 count unchanged at full", fill_reg, 16'h0010);
    chk("R13 no overrun with read", ovr, 0);
    for (int i = 1; i < 16; i++) exp_q.push_back(8'h40 + 8'(i));
    exp_q.push_back(8'hC7);
    for (int i = 0; i < 16; i++) begin
      chk("R13 drain order", rd_data, exp_q.pop_front());
      pop();
    end
    chk("R3 drained", fill_reg, 16'h0000);

    // store and read together with one entry
    send(8'h21, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    send(8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R13 count one kept", fill_reg, 16'h0001);
    chk("R13 new byte at head", rd_data, 8'h22);
    pop();
    clear_all();

    // break
    hold(1'b0, 480);
    chk("R9 break flag", brk, 1);
    chk("R8 break framing error", ferr, 1);
    chk("R9 nothing stored in break", fill_reg, 16'h0000);
    chk("R11 level low in break", rxd_level, 0);
    clr_brk = 1'b1; @(negedge clk); clr_brk = 1'b0;
    chk("R10 break flag re-set", brk, 1);
    hold(1'b1, 40);
    clear_all();
    repeat (5) @(negedge clk);
    chk("R9 break over", brk, 0);
    chk("R9 junk frame withheld", fill_reg, 16'h0000);
    send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 reception resumes", fill_reg, 16'h0001);
    chk("R9 resumed byte", rd_data, 8'h5A);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule